// File: doc/BRIEF.md
# Chip-Select Group Address Decoder

This block turns CPU bus cycles into active-low chip-select strobes for one group of two external devices, such as a pair of memories. A group base register sets where the group sits in the address map. Each select has its own control register, which holds an enable, a read-only flag and a size code. The group window is twice the size of select 0 and must start on a boundary of that size. Select 0 decodes the lower half of the window and select 1 decodes the upper half.

Select 0 is the boot select. It decodes from reset with the largest size, so a boot device answers before any software has run. Interrupt-acknowledge cycles never produce a select. A write to a read-only select is blocked: it gets no select and no acknowledge, and it raises a bus-error request when the bus-error function is enabled. Every output is registered.

Top module: `csg_decoder`

## Requirements
- R1: After reset, both chip-selects are high (inactive), the acknowledge and the bus-error request are low, and the base register reads 0x0000.
- R2: Register address 0 is the base register. Bits 15:1 are writable and hold address bits 28:14 of the window start. Bit 0 always reads 0. Register address 3 reads 0x0000.
- R3: Register addresses 1 and 2 are the control registers of select 0 and select 1. The fields are: bit 0 enable, bit 1 read-only, bits 3:2 size code. Size codes 0, 1, 2 and 3 give a select size of 128 KiB, 512 KiB, 2 MiB and 8 MiB. All other bits read 0.
- R4: From reset until the first write to register address 1, select 0 behaves as enabled, read/write, with size code 3, and register address 1 reads 0x000D.
- R5: A cycle is inside the group when address bits 28:W equal the same bits of the base. Here W = 18 + 2 × (size code of select 0). Base bits below W are ignored.
- R6: Inside the group, address bit W-1 equal to 0 picks select 0 (cs_n = 2'b10), and equal to 1 picks select 1 (cs_n = 2'b01).
- R7: A select whose enable bit is 0 never asserts and produces no acknowledge.
- R8: A cycle with the interrupt-acknowledge input high asserts no chip-select and no acknowledge.
- R9: A write (bus_rw = 0) to a read-only select asserts neither that select nor the acknowledge. It raises berr_req only when berr_en is 1. Reads of that select work normally.
- R10: The chip-selects, acknowledge and bus-error request change one clock after the strobe is sampled with a match. They deassert on the clock after the strobe is sampled low.
- R11: At most one chip-select is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 select 0 control, 2 select 1 control |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| bus_addr | input | 29 | Bus address |
| bus_rw | input | 1 | 1 for a read, 0 for a write |
| bus_as | input | 1 | Address strobe, active high |
| bus_iack | input | 1 | High during an interrupt-acknowledge cycle |
| berr_en | input | 1 | Enables the bus-error request on protected writes |
| cs_n | output | 2 | Active-low chip-selects, bit i for select i |
| xfer_ack | output | 1 | Internal transfer acknowledge |
| berr_req | output | 1 | Bus-error request for a blocked write |

## Verification
The assertions assume that the address, direction and cycle-type inputs stay constant while the strobe is held. They also assume that the registers are not written in the middle of a bus cycle. The stimulus follows both rules. Each bus cycle drives its inputs and raises the strobe together on a falling edge, and holds them until the strobe drops. Register writes happen only while the strobe is low. Outputs are sampled on falling edges, so every check falls one registered stage after the inputs were taken.

// File: rtl/csg_pkg.sv
package csg_pkg;
  localparam int ADDR_W     = 29;
  localparam int REG_W      = 16;
  localparam int BASE_LSB   = 14;
  localparam int NSEL       = 2;
  localparam int SZ_CODES   = 4;
  localparam int MIN_WIN_LG = 18;  // window of size code 0: 2 x 128 KiB

  typedef struct packed {
    logic [1:0] size;
    logic       ro;
    logic       en;
  } sel_ctl_t;

  localparam sel_ctl_t BOOT_CTL = '{size: 2'd3, ro: 1'b0, en: 1'b1};
endpackage

// File: rtl/csg_regs.sv
module csg_regs
  import csg_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int NS = NSEL
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [1:0]            addr,
  input  logic [RW-1:0]         wdata,
  output logic [RW-1:0]         rdata,
  output logic [RW-1:0]         base_q,
  output sel_ctl_t [NS-1:0]     ctl_eff
);
  localparam int CW = $bits(sel_ctl_t);

  logic boot_q;
  sel_ctl_t ctl_q [NS];

  // base register, bit 0 held at zero
  always_ff @(posedge clk) begin
    if (rst) base_q <= '0;
    else if (wr && addr == 2'd0) base_q <= {wdata[RW-1:1], 1'b0};
  end

  // boot override stays until select 0 control is first written
  always_ff @(posedge clk) begin
    if (rst) boot_q <= 1'b1;
    else if (wr && addr == 2'd1) boot_q <= 1'b0;
  end

  for (genvar i = 0; i < NS; i++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (rst) ctl_q[i] <= '0;
      else if (wr && addr == 2'(i + 1)) ctl_q[i] <= sel_ctl_t'(wdata[CW-1:0]);
    end
    if (i == 0) begin : g_boot
      assign ctl_eff[i] = boot_q ? BOOT_CTL : ctl_q[i];
    end else begin : g_plain
      assign ctl_eff[i] = ctl_q[i];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == 2'd0) rdata = base_q;
    for (int i = 0; i < NS; i++)
      if (addr == 2'(i + 1)) rdata = RW'(ctl_eff[i]);
  end

  // R4: the boot override ends only through a write to select 0 control
  p_boot_exit_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(boot_q) |-> $past(wr && addr == 2'd1));

  // R2: base takes the written upper bits with bit 0 cleared
  p_base_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == 2'd0) |=> base_q == {$past(wdata[RW-1:1]), 1'b0});
endmodule

// File: rtl/csg_window.sv
module csg_window
  import csg_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int RW   = REG_W,
  parameter int BLSB = BASE_LSB
) (
  input  logic [AW-1:0] bus_addr,
  input  logic [RW-1:0] base,
  input  logic [1:0]    size_code,
  output logic          in_win,
  output logic          upper
);
  logic [AW-1:0]       base_addr;
  logic [SZ_CODES-1:0] m_c;
  logic [SZ_CODES-1:0] h_c;

  assign base_addr = {base[RW-1:1], {BLSB{1'b0}}};

  // one comparator per size code, the code picks the result
  for (genvar c = 0; c < SZ_CODES; c++) begin : g_code
    localparam int WL = MIN_WIN_LG + 2 * c;
    assign m_c[c] = bus_addr[AW-1:WL] == base_addr[AW-1:WL];
    assign h_c[c] = bus_addr[WL-1];
  end

  assign in_win = m_c[size_code];
  assign upper  = h_c[size_code];
endmodule

// File: rtl/csg_strobe.sv
module csg_strobe
  import csg_pkg::*;
#(
  parameter int NS = NSEL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              as,
  input  logic              rw,
  input  logic              iack,
  input  logic              berr_en,
  input  logic              in_win,
  input  logic              upper,
  input  sel_ctl_t [NS-1:0] ctl,
  output logic [NS-1:0]     cs_n,
  output logic              ack,
  output logic              berr_req
);
  logic [NS-1:0] hit;
  logic [NS-1:0] viol;

  for (genvar i = 0; i < NS; i++) begin : g_sel
    logic go;
    assign go      = as && !iack && in_win && (upper == 1'(i)) && ctl[i].en;
    assign viol[i] = go && ctl[i].ro && !rw;
    assign hit[i]  = go && !(ctl[i].ro && !rw);

    // R7: a disabled select stays inactive on the next clock
    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      !ctl[i].en |=> cs_n[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n     <= '1;
      ack      <= 1'b0;
      berr_req <= 1'b0;
    end else begin
      cs_n     <= ~hit;
      ack      <= |hit;
      berr_req <= berr_en && |viol;
    end
  end

  // R8: interrupt acknowledge never selects
  p_iack_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    iack |=> (&cs_n && !ack));

  // R10: outputs drop on the clock after the strobe is low
  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    !as |=> (&cs_n && !ack && !berr_req));

  // R11: never two selects at once
  p_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // R9: a bus-error request comes without select or acknowledge
  p_ro_block_r9: assert property (@(posedge clk) disable iff (rst)
    berr_req |-> (&cs_n && !ack));
endmodule

// File: rtl/csg_decoder.sv
module csg_decoder
  import csg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rw,
  input  logic              bus_as,
  input  logic              bus_iack,
  input  logic              berr_en,
  output logic [NSEL-1:0]   cs_n,
  output logic              xfer_ack,
  output logic              berr_req
);
  logic [REG_W-1:0]    base_q;
  sel_ctl_t [NSEL-1:0] ctl_eff;
  logic                in_win;
  logic                upper;

  csg_regs #(.RW(REG_W), .NS(NSEL)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .base_q  (base_q),
    .ctl_eff (ctl_eff)
  );

  // select 0 size sets the window of the whole group
  csg_window #(.AW(ADDR_W), .RW(REG_W), .BLSB(BASE_LSB)) u_window (
    .bus_addr  (bus_addr),
    .base      (base_q),
    .size_code (ctl_eff[0].size),
    .in_win    (in_win),
    .upper     (upper)
  );

  csg_strobe #(.NS(NSEL)) u_strobe (
    .clk      (clk),
    .rst      (rst),
    .as       (bus_as),
    .rw       (bus_rw),
    .iack     (bus_iack),
    .berr_en  (berr_en),
    .in_win   (in_win),
    .upper    (upper),
    .ctl      (ctl_eff),
    .cs_n     (cs_n),
    .ack      (xfer_ack),
    .berr_req (berr_req)
  );
endmodule

// File: tb/csg_decoder_tb.sv
module csg_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [28:0] bus_addr = '0;
  logic        bus_rw = 1'b1;
  logic        bus_as = 1'b0;
  logic        bus_iack = 1'b0;
  logic        berr_en = 1'b0;
  logic [1:0]  cs_n;
  logic        xfer_ack;
  logic        berr_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  csg_decoder u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_addr(bus_addr),
    .bus_rw(bus_rw), .bus_as(bus_as), .bus_iack(bus_iack), .berr_en(berr_en),
    .cs_n(cs_n), .xfer_ack(xfer_ack), .berr_req(berr_req)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, 32'(reg_rdata), 32'(exp));
  endtask

  // one bus cycle; expected {cs_n, ack, berr}
  task automatic cyc(input logic [28:0] a, input bit rw, input bit iack,
                     input logic [3:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rw = rw; bus_iack = iack; bus_as = 1'b1;
    @(negedge clk);
    chk({cs_n, xfer_ack, berr_req} == exp, tag, 32'({cs_n, xfer_ack, berr_req}), 32'(exp));
    bus_as = 1'b0; bus_iack = 1'b0;
    @(negedge clk);
    chk({cs_n, xfer_ack, berr_req} == 4'b1100, "R10 release", 32'({cs_n, xfer_ack, berr_req}), 32'hC);
  endtask

  localparam logic [3:0] SEL0 = 4'b1010;
  localparam logic [3:0] SEL1 = 4'b0110;
  localparam logic [3:0] NONE = 4'b1100;
  localparam logic [3:0] BERR = 4'b1101;

  task automatic t_reset;
    chk({cs_n, xfer_ack, berr_req} == NONE, "R1 outputs idle", 32'({cs_n, xfer_ack, berr_req}), 32'(NONE));
    rd_chk(2'd0, 16'h0000, "R1 base reset");
    rd_chk(2'd1, 16'h000D, "R4 boot control readback");
    rd_chk(2'd2, 16'h0000, "R3 select 1 control reset");
  endtask

  task automatic t_boot;
    cyc(29'h0000100, 1'b1, 1'b0, SEL0, "R4 boot read");
    cyc(29'h07FFFFE, 1'b0, 1'b0, SEL0, "R4 boot write top of half");
    cyc(29'h0800000, 1'b1, 1'b0, NONE, "R7 select 1 disabled");
    cyc(29'h1000000, 1'b1, 1'b0, NONE, "R5 outside boot window");
  endtask

  task automatic t_regs;
    wr_reg(2'd0, 16'h0201);
    rd_chk(2'd0, 16'h0200, "R2 base bit0 reads zero");
    rd_chk(2'd3, 16'h0000, "R2 unused address");
    wr_reg(2'd1, 16'hFFF9);
    rd_chk(2'd1, 16'h0009, "R3 control mask");
    wr_reg(2'd2, 16'h0009);
    rd_chk(2'd2, 16'h0009, "R3 select 1 control");
  endtask

  task automatic t_window;
    cyc(29'h0400010, 1'b1, 1'b0, SEL0, "R6 lower half");
    cyc(29'h0600010, 1'b1, 1'b0, SEL1, "R6 upper half");
    cyc(29'h0000010, 1'b1, 1'b0, NONE, "R5 below base");
    cyc(29'h0C00010, 1'b1, 1'b0, NONE, "R5 high bit differs");
    wr_reg(2'd0, 16'h0202);
    cyc(29'h0400010, 1'b1, 1'b0, SEL0, "R5 low base bits ignored");
    wr_reg(2'd0, 16'h0200);
  endtask

  task automatic t_enable;
    wr_reg(2'd2, 16'h0008);
    cyc(29'h0600010, 1'b1, 1'b0, NONE, "R7 disabled select 1");
    wr_reg(2'd2, 16'h0009);
  endtask

  task automatic t_iack;
    cyc(29'h0400010, 1'b1, 1'b1, NONE, "R8 iack no select");
  endtask

  task automatic t_ro;
    wr_reg(2'd1, 16'h000B);
    berr_en = 1'b0;
    cyc(29'h0400010, 1'b0, 1'b0, NONE, "R9 protected write quiet");
    berr_en = 1'b1;
    cyc(29'h0400010, 1'b0, 1'b0, BERR, "R9 protected write bus error");
    cyc(29'h0400010, 1'b1, 1'b0, SEL0, "R9 protected read works");
    cyc(29'h0600010, 1'b0, 1'b0, SEL1, "R9 other select writable");
    berr_en = 1'b0;
    wr_reg(2'd1, 16'h0009);
  endtask

  task automatic t_small;
    wr_reg(2'd1, 16'h0001);
    cyc(29'h0400000, 1'b1, 1'b0, SEL0, "R5 code0 lower");
    cyc(29'h0420000, 1'b1, 1'b0, SEL1, "R6 code0 upper");
    cyc(29'h0440000, 1'b1, 1'b0, NONE, "R5 code0 outside");
    wr_reg(2'd1, 16'h0009);
  endtask

  task automatic t_timing;
    @(negedge clk);
    bus_addr = 29'h0400010; bus_rw = 1'b1; bus_as = 1'b1;
    #1;
    chk({cs_n, xfer_ack} == 3'b110, "R10 not before clock", 32'({cs_n, xfer_ack}), 32'h6);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk({cs_n, xfer_ack} == 3'b101, "R10 held while strobe", 32'({cs_n, xfer_ack}), 32'h5);
    end
    bus_as = 1'b0;
    #1;
    chk({cs_n, xfer_ack} == 3'b101, "R10 stays until clock", 32'({cs_n, xfer_ack}), 32'h5);
    @(negedge clk);
    chk({cs_n, xfer_ack} == 3'b110, "R10 drops after release", 32'({cs_n, xfer_ack}), 32'h6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_boot;
    t_regs;
    t_window;
    t_enable;
    t_iack;
    t_ro;
    t_small;
    t_timing;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule